// File: doc/BRIEF.md
# Request-Triggered Serial Identifier Sender

This controller sits idle with its serial line low until a request line, which may change at any time relative to the clock, is seen high. The request is first re-timed through a synchronizer flop, so the controller always responds exactly one cycle later than an unsynchronized design would. Once a request is seen in idle, the controller sends a fixed identifier of `ID_W` bits, most significant bit first, one bit per clock. It then returns to idle without any further input.

The state register is a binary slot counter `$clog2(ID_W+1)` bits wide. Slot 0 is the idle state (named IDLE). Slot k (1..ID_W) sends identifier bit `ID_W-k`. With the default width of 4, this gives idle = 000 and the transmit slots 001 to 100. For decoding, each slot is classified into one of four phases. IDLE is slot 0. FIRST is slot 1. MID is any slot strictly between 1 and ID_W. FINAL is slot ID_W.

The transitions are as follows:
- IDLE to IDLE while the synchronized request is low.
- IDLE to FIRST when the synchronized request is high.
- FIRST or MID to the next slot, unconditionally.
- FINAL to IDLE, unconditionally.

The `busy` output frames the transmitted bits. A request that is still high after a burst ends starts the next burst after one idle cycle.

Top module: `id_tx`

## Requirements
- R1: In IDLE, `tx_bit` and `busy` are 0, and the controller stays in IDLE while the synchronized request is 0.
- R2: A request driven high before clock edge E is captured by the synchronizer at E. The controller enters FIRST at edge E+1, so `busy` is first high after E+1. A request that is high for a single cycle is enough to start a burst.
- R3: During a burst, `tx_bit` carries the identifier MSB first, one bit per cycle. With the default `ID_VALUE` = 4'b1101, the sequence is 1, 1, 0, 1.
- R4: `busy` is high for exactly `ID_W` consecutive cycles per burst. At the edge after FINAL, the controller returns to IDLE.
- R5: A request that rises during a burst is ignored. The burst length and bit values do not change, and no new burst follows if the request has fallen before the controller is back in IDLE.
- R6: A request held high continuously gives repeated bursts, each separated by exactly one IDLE cycle.
- R7: Synchronous reset `rst` forces the controller to IDLE and clears the synchronizer. After the reset edge, `busy` and `tx_bit` are 0, even if a burst was in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_async | input | 1 | Asynchronous request line |
| tx_bit | output | 1 | Serial identifier bit, 0 when idle |
| busy | output | 1 | High in every transmit slot |

## Verification
The bench checks the one-cycle synchronizer latency by placing a single-cycle request pulse and checking that `busy` rises two edges later, not one. A design without the synchronizer would show `busy` one cycle early. A design that sampled the raw request would miss nothing here, but would fail the timing check.

A request pulse inside a burst checks that a design which restarts or extends the burst would stretch `busy` past four cycles. A held request checks for the single idle gap between bursts. A design that chains FINAL straight into FIRST would show no gap.

Reset asserted in the middle of a burst must drop `busy` and `tx_bit` at the very next edge.

// File: rtl/id_tx_pkg.sv
package id_tx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FIRST = 2'd1,
        PH_MID   = 2'd2,
        PH_FINAL = 2'd3
    } phase_e;

    function automatic phase_e classify_slot(input int unsigned slot,
                                             input int unsigned last);
        phase_e p;
        if (slot == 0)          p = PH_IDLE;
        else if (slot == last)  p = PH_FINAL;
        else if (slot == 1)     p = PH_FIRST;
        else                    p = PH_MID;
        return p;
    endfunction

endpackage

// File: rtl/id_tx_sync.sv
module id_tx_sync #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b0;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/id_tx_seq.sv
module id_tx_seq
    import id_tx_pkg::*;
#(
    parameter int ID_W = 4,
    localparam int SW  = $clog2(ID_W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_s,
    output logic [SW-1:0] slot,
    output phase_e        phase
);
    localparam logic [SW-1:0] SLOT_IDLE  = '0;
    localparam logic [SW-1:0] SLOT_FIRST = SW'(1);

    logic [SW-1:0] slot_nx;

    always_comb begin
        phase = classify_slot(int'(slot), ID_W);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) slot <= SLOT_IDLE;
        else     slot <= slot_nx;
    end

    // next-state logic
    always_comb begin
        slot_nx = slot;
        unique case (phase)
            PH_IDLE:  slot_nx = req_s ? SLOT_FIRST : SLOT_IDLE;
            PH_FIRST: slot_nx = slot + SW'(1);
            PH_MID:   slot_nx = slot + SW'(1);
            PH_FINAL: slot_nx = SLOT_IDLE;
        endcase
    end
endmodule

// File: rtl/id_tx_out.sv
module id_tx_out
    import id_tx_pkg::*;
#(
    parameter int              ID_W     = 4,
    parameter logic [ID_W-1:0] ID_VALUE = 4'b1101,
    localparam int             SW       = $clog2(ID_W + 1)
) (
    input  logic [SW-1:0] slot,
    input  phase_e        phase,
    output logic          tx_bit,
    output logic          busy
);
    always_comb begin
        busy   = 1'b0;
        tx_bit = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                busy   = 1'b0;
                tx_bit = 1'b0;
            end
            PH_FIRST, PH_MID, PH_FINAL: begin
                busy = 1'b1;
                for (int k = 1; k <= ID_W; k++) begin
                    if (slot == SW'(k)) tx_bit = ID_VALUE[ID_W-k];
                end
            end
        endcase
    end
endmodule

// File: rtl/id_tx.sv
module id_tx
    import id_tx_pkg::*;
#(
    parameter int              ID_W        = 4,
    parameter logic [ID_W-1:0] ID_VALUE    = 4'b1101,
    parameter int              SYNC_STAGES = 1,
    localparam int             SW          = $clog2(ID_W + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    output logic tx_bit,
    output logic busy
);
    logic          req_s;
    logic [SW-1:0] slot;
    phase_e        phase;

    id_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (req_async),
        .dout(req_s)
    );

    id_tx_seq #(.ID_W(ID_W)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .req_s(req_s),
        .slot (slot),
        .phase(phase)
    );

    id_tx_out #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_out (
        .slot  (slot),
        .phase (phase),
        .tx_bit(tx_bit),
        .busy  (busy)
    );
endmodule

// File: rtl/id_tx_chk.sv
module id_tx_chk #(
    parameter int              ID_W        = 4,
    parameter logic [ID_W-1:0] ID_VALUE    = 4'b1101,
    parameter int              SYNC_STAGES = 1,
    localparam int             PW          = $clog2(ID_W) + 1
) (
    input logic clk,
    input logic rst,
    input logic req_async,
    input logic req_s,
    input logic tx_bit,
    input logic busy
);
    logic [PW-1:0] pos;
    logic          exp_bit;

    always_ff @(posedge clk) begin
        if (rst || !busy) pos <= '0;
        else              pos <= pos + PW'(1);
    end

    always_comb begin
        exp_bit = 1'b0;
        for (int k = 0; k < ID_W; k++) begin
            if (pos == PW'(k)) exp_bit = ID_VALUE[ID_W-1-k];
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tx_bit);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_s) |=> !busy);

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_s) |=> busy);

    p_bit_order_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (tx_bit == exp_bit));

    p_burst_end_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && pos == PW'(ID_W-1)) |=> !busy);

    p_burst_run_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && pos < PW'(ID_W-1)) |=> busy);

    p_reset_idle_r7: assert property (@(posedge clk)
        rst |=> (!busy && !tx_bit));

    generate
        if (SYNC_STAGES == 1) begin : g_sync_chk
            p_sync_rise_r2: assert property (@(posedge clk) disable iff (rst)
                req_async |=> req_s);
            p_sync_fall_r2: assert property (@(posedge clk) disable iff (rst)
                !req_async |=> !req_s);
        end
    endgenerate
endmodule

bind id_tx id_tx_chk #(
    .ID_W(ID_W), .ID_VALUE(ID_VALUE), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_async(req_async),
    .req_s    (req_s),
    .tx_bit   (tx_bit),
    .busy     (busy)
);

// File: tb/id_tx_test.sv
module id_tx_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic tx_bit, busy;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #10 clk = ~clk;

    id_tx uut (
        .clk      (clk),
        .rst      (rst),
        .req_async(req),
        .tx_bit   (tx_bit),
        .busy     (busy)
    );

    // {req to drive, expected busy, expected tx_bit}; outputs checked first
    localparam int NV = 20;
    localparam logic [2:0] VEC [NV] = '{
        3'b100, // 0  R2 single-cycle pulse, idle
        3'b000, // 1  R2 only synchronized yet
        3'b011, // 2  R3 bit 1
        3'b111, // 3  R5 pulse inside burst, bit 1
        3'b010, // 4  R3 bit 0
        3'b011, // 5  R3 bit 1
        3'b000, // 6  R4/R5 back idle, no restart
        3'b100, // 7  R6 hold starts
        3'b100, // 8  R1 still idle
        3'b111, // 9
        3'b111, // 10
        3'b110, // 11
        3'b111, // 12
        3'b100, // 13 R6 one idle gap
        3'b011, // 14 R6 next burst, release
        3'b011, // 15
        3'b010, // 16
        3'b011, // 17
        3'b000, // 18 R1 idle
        3'b000  // 19 R1 stays idle
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset busy", busy, 1'b0);
        check("R7 reset tx", tx_bit, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle busy", busy, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check($sformatf("R3 vec%0d busy", i), busy, VEC[i][1]);
            check($sformatf("R3 vec%0d tx", i), tx_bit, VEC[i][0]);
            req = VEC[i][2];
        end

        // R7: reset in the middle of a burst
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 burst started", busy, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check("R7 mid-burst busy", busy, 1'b0);
        check("R7 mid-burst tx", tx_bit, 1'b0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 no resume after reset", busy, 1'b0);

        // R7: request present during reset is cleared from the synchronizer
        req = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        req = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R7 sync cleared", busy, 1'b0);
        @(negedge clk);
        check("R7 sync cleared late", busy, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule